// File: doc/BRIEF.md
# Serial ADC Command and Readback Controller

This controller runs one conversion on a 3-wire serial analog-to-digital converter that has no chip select. It uses a serial clock output, a command data output (`sdi`, into the converter) and a response data input (`sdo`, from the converter). A request on `start` names one of four logical channels. The block turns that channel into a fixed physical select code and builds an 8-bit control byte. It shifts the byte out most significant bit first and waits a programmable number of cycles for the conversion. It then clocks in a 16-bit response.

The upper twelve response bits become the result. The lowest four bits are padding and must read back as zero. A non-zero pad shows a converter that is absent or badly connected, and raises the error flag. Each serial clock half-period lasts `HALF` system clocks. `GAP` system clocks separate the command from the response.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The control byte is `{1'b1, sel[2:0], 4'b1110}`. Bit 7 is the start bit, bits 6..4 are the select code and bits 3..0 are the fixed unipolar, single-ended, internal-clock code. The byte is sent bit 7 first.
- R2: Logical channels map to select codes as follows: 0→1, 1→5, 2→2 and 3→6.
- R3: `sclk` is low whenever the block is idle. Every serial clock high phase lasts exactly `HALF` cycles. During the command, every low phase also lasts `HALF` cycles. `sdi` changes only while `sclk` is low.
- R4: From the last command falling edge to the first response rising edge, `sclk` stays low for exactly `GAP + HALF` cycles.
- R5: The response uses exactly 16 serial clocks. `sdo` is sampled in each high phase, and the first bit sampled is response bit 15.
- R6: `sdi` is low at every serial clock rising edge of the response read.
- R7: `result` equals response bits 15..4. It is updated only in the cycle in which `done` is high.
- R8: `err` is high exactly when response bits 3..0 are not all zero. It is updated together with `result`.
- R9: `busy` rises in the cycle after `start` is accepted and stays high for `48*HALF + GAP + 1` cycles. When `busy` falls, `done` is high for exactly one cycle.
- R10: A `start` that arrives while `busy` is high is ignored. It sends no second byte, produces no second `done` and does not change the command in progress.
- R11: After reset, `busy`, `done`, `sclk`, `sdi`, `err` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a conversion; taken only when idle |
| chan | input | 2 | Logical channel of the request |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse: result and error valid |
| result | output | 12 | Converted value |
| err | output | 1 | Non-zero response padding seen |
| sclk | output | 1 | Serial clock to the converter |
| sdi | output | 1 | Command data to the converter |
| sdo | input | 1 | Response data from the converter |

## Verification
With `HALF = 2` and `GAP = 3`, `done` is due exactly 100 cycles after the clock edge that accepts `start`. The bench counts the `busy` cycles between those two points and compares the count with `48*HALF + GAP + 1`. On every falling system edge, the bench measures how long each serial clock level lasts. It compares each measured length with `HALF`, except the pause before the response, which it compares with `GAP + HALF`. A converter model in the bench captures the byte on the serial rising edges and presents each response bit one nanosecond after a rise. Each bit is therefore settled well before the last cycle of the high phase, when it is sampled. `result`, `err` and the `done` width are read on falling system edges in the `done` cycle and the cycle after it.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int HALF = 4,
  parameter int GAP  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  chan,
  output logic        busy,
  output logic        done,
  output logic [11:0] result,
  output logic        err,
  output logic        sclk,
  output logic        sdi,
  input  logic        sdo
);
  localparam int CW = $clog2(HALF + 1);
  localparam int GW = $clog2(GAP + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_GAP, S_READ, S_FIN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [GW-1:0] gcnt;
  logic          ph;
  logic [3:0]    bcnt;
  logic [7:0]    cmd;
  logic [15:0]   shr;

  wire half_end = (cnt == CW'(HALF - 1));

  function automatic logic [2:0] sel_of(input logic [1:0] c);
    case (c)
      2'd0:    sel_of = 3'd1;
      2'd1:    sel_of = 3'd5;
      2'd2:    sel_of = 3'd2;
      default: sel_of = 3'd6;
    endcase
  endfunction

  assign busy = (st != S_IDLE);
  assign sclk = ph && (st == S_CMD || st == S_READ);
  assign sdi  = (st == S_CMD) && cmd[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      gcnt   <= '0;
      ph     <= 1'b0;
      bcnt   <= '0;
      cmd    <= '0;
      shr    <= '0;
      result <= '0;
      err    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cmd  <= {1'b1, sel_of(chan), 4'b1110};
          cnt  <= '0;
          ph   <= 1'b0;
          bcnt <= '0;
          st   <= S_CMD;
        end
        S_CMD: if (half_end) begin
          cnt <= '0;
          ph  <= ~ph;
          if (ph) begin
            cmd  <= {cmd[6:0], 1'b0};
            bcnt <= bcnt + 4'd1;
            if (bcnt == 4'd7) begin
              bcnt <= '0;
              gcnt <= '0;
              st   <= S_GAP;
            end
          end
        end else cnt <= cnt + CW'(1);
        S_GAP: if (gcnt == GW'(GAP - 1)) begin
          cnt <= '0;
          ph  <= 1'b0;
          st  <= S_READ;
        end else gcnt <= gcnt + GW'(1);
        S_READ: if (half_end) begin
          cnt <= '0;
          ph  <= ~ph;
          if (ph) begin
            shr  <= {shr[14:0], sdo};
            bcnt <= bcnt + 4'd1;
            if (bcnt == 4'd15) st <= S_FIN;
          end
        end else cnt <= cnt + CW'(1);
        S_FIN: begin
          result <= shr[15:4];
          err    <= |shr[3:0];
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [11:0] result,
  input logic        err,
  input logic        sclk,
  input logic        sdi
);
  a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  a_r3_sdi_still_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdi));
  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  a_r8_err_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(err));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .result(result), .err(err), .sclk(sclk), .sdi(sdi)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  localparam int H   = 2;
  localparam int G   = 3;
  localparam int LAT = 48 * H + G + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] chan = 2'd0;
  logic sdo = 1'b0;
  logic busy, done, err, sclk, sdi;
  logic [11:0] result;

  int tests = 0, fails = 0;

  logic [15:0] resp;
  logic [7:0]  cap;
  int          nrise;
  int          sdi_bad;
  int          hi_bad, lo_bad, gap_bad;
  logic        prev_sclk = 1'b0;
  int          run = 0;

  adc_seq_ctrl #(.HALF(H), .GAP(G)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan),
    .busy(busy), .done(done), .result(result), .err(err),
    .sclk(sclk), .sdi(sdi), .sdo(sdo)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Converter model: take command on rising edges, present response after rises
  always @(posedge sclk) begin
    if (nrise < 8) cap = {cap[6:0], sdi};
    else begin
      if (sdi) sdi_bad++;
      #1 sdo = resp[15 - (nrise - 8)];
    end
    nrise++;
  end

  // Level-length monitor on falling system edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk == prev_sclk) run++;
      else begin
        if (prev_sclk) begin
          if (run != H) hi_bad++;
        end else if (nrise == 9) begin
          if (run != G + H) gap_bad++;
        end else if (nrise > 1 && nrise <= 8) begin
          if (run != H) lo_bad++;
        end
        run = 1;
      end
      prev_sclk = sclk;
    end
  end

  function automatic logic [2:0] exp_sel(input logic [1:0] c);
    case (c)
      2'd0: return 3'd1;
      2'd1: return 3'd5;
      2'd2: return 3'd2;
      default: return 3'd6;
    endcase
  endfunction

  task automatic run_one(input logic [1:0] c, input logic [11:0] v,
                         input logic [3:0] pad, input bit inject);
    int lat;
    int extra_done;
    logic [7:0] exp_b;
    resp = {v, pad};
    nrise = 0; cap = '0; sdi_bad = 0; hi_bad = 0; lo_bad = 0; gap_bad = 0;
    exp_b = {1'b1, exp_sel(c), 4'b1110};
    @(negedge clk);
    chan = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 4 * LAT) begin
      if (busy) lat++;
      if (inject && lat == 30) begin start = 1'b1; chan = ~c; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(lat == LAT, "R9 busy length", lat, LAT);
    chk(cap == exp_b, "R1 R2 control byte", cap, exp_b);
    chk(nrise == 24, "R5 serial clock count", nrise, 24);
    chk(hi_bad == 0 && lo_bad == 0, "R3 half-period length", hi_bad + lo_bad, 0);
    chk(gap_bad == 0, "R4 gap length", gap_bad, 0);
    chk(sdi_bad == 0, "R6 sdi low in read", sdi_bad, 0);
    chk(result == v, "R7 result", result, v);
    chk(err == (pad != 0), "R8 error flag", err, pad != 0);
    @(negedge clk);
    chk(!done && !busy, "R9 done width", done, 0);
    if (inject) begin
      extra_done = 0;
      repeat (LAT + 10) begin
        @(negedge clk);
        if (done || busy) extra_done++;
      end
      chk(extra_done == 0 && nrise == 24, "R10 start while busy ignored", extra_done, 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    resp = '0; cap = '0; nrise = 0;
    sdi_bad = 0; hi_bad = 0; lo_bad = 0; gap_bad = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !sclk && !sdi && !err && result == 0,
        "R11 reset state", {busy, done, sclk, sdi, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      run_one(2'(c), 12'h000, 4'h0, 1'b0);
      run_one(2'(c), 12'hFFF, 4'h0, 1'b0);
      run_one(2'(c), 12'hA5C ^ 12'(c * 12'h111), 4'h0, 1'b0);
      run_one(2'(c), 12'h3C6 + 12'(c), 4'(1 << c), 1'b0);
    end
    run_one(2'd3, 12'h800, 4'hF, 1'b0);
    run_one(2'd1, 12'h001, 4'h8, 1'b0);
    run_one(2'd2, 12'h5A5, 4'h0, 1'b1);
    run_one(2'd0, 12'h123, 4'h0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule